// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block guards the configuration store of a programmable logic core. The store holds three things: a bank of logic pattern rows, an eight-byte signature area for the user's own identification data, and a single protection bit. Commands arrive on a valid/ready handshake. Every accepted command produces one response beat on the next cycle. The beat carries read data and a flag that marks a refused command. A separate strobe forces a chosen value into the core's output registers before a test run.

Once the protection bit is set, pattern rows can still be written but can no longer be read back, and register forcing is refused. The signature area stays fully readable and writable. The protection bit is one-way: it is set by a command, applies from the very next command on, and is removed only by a bulk erase. The erase walks the pattern bank one row per cycle and stalls the handshake while it runs.

Top module: `cfg_access_ctrl`

## Requirements
- R1: Reset is synchronous and active-high. When reset is released, cmd_ready is 1, rsp_valid, rsp_reject and pl_strobe are 0, pl_value is 0, protection is off, and every pattern row and signature byte reads as 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. Exactly one cycle later, rsp_valid is 1 for one cycle. rsp_valid is 0 in every other cycle, and rsp_data is 0 whenever rsp_valid is 0 or rsp_reject is 1.
- R3: Op code 0 writes cmd_wdata into the row selected by cmd_addr. Op code 1 returns that row's content on rsp_data while protection is off.
- R4: Op code 3 writes cmd_wdata[7:0] into the signature byte selected by cmd_addr[2:0]. Op code 2 returns that byte zero-extended on rsp_data. Neither is ever refused, whatever the protection state.
- R5: Op code 4 sets protection. Every op 1 accepted after it, including one accepted on the very next edge, is refused with rsp_reject = 1 and no data.
- R6: Op code 5 with protection off pulses pl_strobe for one cycle, one cycle after acceptance, and pl_value becomes cmd_wdata[NREG-1:0] and holds it afterwards. With protection on, op 5 is refused, pl_strobe stays 0 and pl_value is unchanged.
- R7: Op code 0 is accepted without refusal while protection is on.
- R8: Op code 6 erases. cmd_ready is 0 for exactly ROWS cycles after the accepting edge. When it returns to 1, every pattern row reads 0 and protection is off. Signature bytes and pl_value are unchanged.
- R9: Op code 7 is refused and changes no state.
- R10: Protection is sticky. No command other than op 6 clears it, and a repeated op 4 is accepted without refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation code (0..7, see R3 to R9) |
| cmd_addr | input | ADDR_W (4) | Row index, or signature byte index in bits [2:0] |
| cmd_wdata | input | ROW_W (32) | Write data / register force value |
| rsp_valid | output | 1 | Response beat |
| rsp_reject | output | 1 | Command was refused |
| rsp_data | output | ROW_W (32) | Read data, zero unless a permitted read |
| pl_strobe | output | 1 | One-cycle register force pulse |
| pl_value | output | NREG (8) | Value forced into the output registers |

## Verification
Every response field and the force strobe are due on the edge right after the accepting edge. After an erase is accepted, cmd_ready is due to stay low for exactly ROWS cycles. The bench runs a behavioural model that takes the same inputs at each rising edge and yields the values expected after it. It compares all outputs at the following falling edge, so each result is checked in the cycle it is due and never one early or late. Commands that are held during an erase are counted by the model as accepted only on the edge after cmd_ready returns.

// File: rtl/cfgac_pkg.sv
package cfgac_pkg;

    typedef enum logic [2:0] {
        OP_FUSE_WR = 3'd0,
        OP_FUSE_RD = 3'd1,
        OP_SIG_RD  = 3'd2,
        OP_SIG_WR  = 3'd3,
        OP_SEC_SET = 3'd4,
        OP_PRELOAD = 3'd5,
        OP_ERASE   = 3'd6,
        OP_RSVD    = 3'd7
    } cfg_op_e;

    localparam int SIG_BYTES = 8;
    localparam int SIG_BW    = 8;
    localparam int SIG_AW    = $clog2(SIG_BYTES);

    typedef struct packed {
        logic wr_fuse;
        logic rd_fuse;
        logic wr_sig;
        logic rd_sig;
        logic set_sec;
        logic preload;
        logic erase;
        logic reject;
    } cmd_dec_t;

    // Turn an op code and the protection state into action enables.
    // A refused command enables no action at all.
    function automatic cmd_dec_t decode_cmd(input cfg_op_e op, input logic prot);
        cmd_dec_t d;
        d = '0;
        unique case (op)
            OP_FUSE_WR: d.wr_fuse = 1'b1;
            OP_FUSE_RD: if (prot) d.reject = 1'b1; else d.rd_fuse = 1'b1;
            OP_SIG_RD:  d.rd_sig  = 1'b1;
            OP_SIG_WR:  d.wr_sig  = 1'b1;
            OP_SEC_SET: d.set_sec = 1'b1;
            OP_PRELOAD: if (prot) d.reject = 1'b1; else d.preload = 1'b1;
            OP_ERASE:   d.erase   = 1'b1;
            default:    d.reject  = 1'b1;
        endcase
        return d;
    endfunction

    function automatic cmd_dec_t gate_dec(input cmd_dec_t d, input logic en);
        return en ? d : '0;
    endfunction

endpackage

// File: rtl/cfgac_fuse_bank.sv
module cfgac_fuse_bank #(
    parameter int ROWS  = 16,
    parameter int ROW_W = 32,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_row,
    input  logic [ROW_W-1:0] wr_data,
    input  logic             clr_en,
    input  logic [AW-1:0]    clr_row,
    input  logic [AW-1:0]    rd_row,
    output logic [ROW_W-1:0] rd_data
);

    logic [ROW_W-1:0] rows_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam logic [AW-1:0] IDX = AW'(r);
        always_ff @(posedge clk) begin
            if (rst) begin
                rows_q[r] <= '0;
            end else if (clr_en && clr_row == IDX) begin
                rows_q[r] <= '0;
            end else if (wr_en && wr_row == IDX) begin
                rows_q[r] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (rd_row == AW'(r)) rd_data = rows_q[r];
        end
    end

endmodule

// File: rtl/cfgac_sig_store.sv
module cfgac_sig_store
    import cfgac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SIG_AW-1:0] wr_idx,
    input  logic [SIG_BW-1:0] wr_byte,
    input  logic [SIG_AW-1:0] rd_idx,
    output logic [SIG_BW-1:0] rd_byte
);

    logic [SIG_BW-1:0] bytes_q [SIG_BYTES];

    for (genvar b = 0; b < SIG_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[b] <= '0;
            end else if (wr_en && wr_idx == SIG_AW'(b)) begin
                bytes_q[b] <= wr_byte;
            end
        end
    end

    assign rd_byte = bytes_q[rd_idx];

endmodule

// File: rtl/cfgac_guard.sv
module cfgac_guard #(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_prot,
    input  logic          erase_go,
    output logic          prot,
    output logic          erasing,
    output logic          clr_en,
    output logic [AW-1:0] clr_row
);

    localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

    logic          prot_q;
    logic          busy_q;
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= 1'b0;
            busy_q <= 1'b0;
            ptr_q  <= '0;
        end else if (busy_q) begin
            if (ptr_q == LAST_ROW) begin
                busy_q <= 1'b0;
                prot_q <= 1'b0;
                ptr_q  <= '0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end else if (erase_go) begin
            busy_q <= 1'b1;
            ptr_q  <= '0;
        end else if (set_prot) begin
            prot_q <= 1'b1;
        end
    end

    assign prot    = prot_q;
    assign erasing = busy_q;
    assign clr_en  = busy_q;
    assign clr_row = ptr_q;

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
    import cfgac_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int ROW_W = 32,
    parameter int NREG  = 8,
    localparam int AW     = $clog2(ROWS),
    localparam int ADDR_W = (AW > SIG_AW) ? AW : SIG_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ROW_W-1:0]  cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_reject,
    output logic [ROW_W-1:0]  rsp_data,
    output logic              pl_strobe,
    output logic [NREG-1:0]   pl_value
);

    logic             accept;
    cmd_dec_t         dec;
    logic             secured;
    logic             erasing;
    logic             clr_en;
    logic [AW-1:0]    clr_row;
    logic [ROW_W-1:0] fuse_rd;
    logic [SIG_BW-1:0] sig_rd;
    logic [ROW_W-1:0] rd_mux;

    assign cmd_ready = ~erasing;
    assign accept    = cmd_valid & cmd_ready;
    assign dec       = gate_dec(decode_cmd(cfg_op_e'(cmd_op), secured), accept);

    cfgac_guard #(.ROWS(ROWS)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .set_prot (dec.set_sec),
        .erase_go (dec.erase),
        .prot     (secured),
        .erasing  (erasing),
        .clr_en   (clr_en),
        .clr_row  (clr_row)
    );

    cfgac_fuse_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.wr_fuse),
        .wr_row  (cmd_addr[AW-1:0]),
        .wr_data (cmd_wdata),
        .clr_en  (clr_en),
        .clr_row (clr_row),
        .rd_row  (cmd_addr[AW-1:0]),
        .rd_data (fuse_rd)
    );

    cfgac_sig_store u_sig (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dec.wr_sig),
        .wr_idx  (cmd_addr[SIG_AW-1:0]),
        .wr_byte (cmd_wdata[SIG_BW-1:0]),
        .rd_idx  (cmd_addr[SIG_AW-1:0]),
        .rd_byte (sig_rd)
    );

    always_comb begin
        rd_mux = '0;
        if (dec.rd_fuse)     rd_mux = fuse_rd;
        else if (dec.rd_sig) rd_mux = ROW_W'(sig_rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_reject <= 1'b0;
            rsp_data   <= '0;
            pl_strobe  <= 1'b0;
            pl_value   <= '0;
        end else begin
            rsp_valid  <= accept;
            rsp_reject <= dec.reject;
            rsp_data   <= rd_mux;
            pl_strobe  <= dec.preload;
            if (dec.preload) pl_value <= cmd_wdata[NREG-1:0];
        end
    end

endmodule

// File: rtl/cfgac_chk.sv
module cfgac_chk #(
    parameter int ROW_W  = 32,
    parameter int NREG   = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              rsp_valid,
    input logic              rsp_reject,
    input logic [ROW_W-1:0]  rsp_data,
    input logic              pl_strobe,
    input logic [NREG-1:0]   pl_value,
    input logic              secured,
    input logic              erasing
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);
    a_r2_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);
    a_r2_quiet_data: assert property (@(posedge clk) disable iff (rst)
        (!rsp_valid || rsp_reject) |-> rsp_data == '0);
    a_r4_sig_never_refused: assert property (@(posedge clk) disable iff (rst)
        (acc && (cmd_op == 3'd2 || cmd_op == 3'd3)) |=> !rsp_reject);
    a_r5_verify_blocked: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd1 && secured) |=> rsp_reject);
    a_r6_force_blocked: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd5 && secured) |=> (!pl_strobe && $stable(pl_value)));
    a_r6_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        pl_strobe |-> $past(acc && cmd_op == 3'd5 && !secured));
    a_r7_write_allowed: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd0) |=> !rsp_reject);
    a_r8_stall_erase: assert property (@(posedge clk) disable iff (rst)
        erasing |-> !cmd_ready);
    a_r8_erase_unlocks: assert property (@(posedge clk) disable iff (rst)
        $fell(erasing) |-> !secured);
    a_r9_reserved_refused: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == 3'd7) |=> rsp_reject);
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (secured && !erasing) |=> secured);

endmodule

bind cfg_access_ctrl cfgac_chk #(
    .ROW_W  (ROW_W),
    .NREG   (NREG),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_reject (rsp_reject),
    .rsp_data   (rsp_data),
    .pl_strobe  (pl_strobe),
    .pl_value   (pl_value),
    .secured    (secured),
    .erasing    (erasing)
);

// File: tb/tb_cfg_access_ctrl.sv
module tb_cfg_access_ctrl;

    localparam int ROWS   = 16;
    localparam int ROW_W  = 32;
    localparam int NREG   = 8;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [ROW_W-1:0]  cmd_wdata = '0;
    logic              cmd_ready;
    logic              rsp_valid;
    logic              rsp_reject;
    logic [ROW_W-1:0]  rsp_data;
    logic              pl_strobe;
    logic [NREG-1:0]   pl_value;

    always #10 clk = ~clk;

    cfg_access_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W), .NREG(NREG)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_reject(rsp_reject), .rsp_data(rsp_data),
        .pl_strobe(pl_strobe), .pl_value(pl_value)
    );

    // ---------------- behavioural model ----------------
    int unsigned       m_fuse [ROWS];
    int unsigned       m_sig  [8];
    bit                m_prot;
    int                m_stall;
    bit                e_ready, e_rv, e_rj, e_pl;
    int unsigned       e_data;
    int unsigned       e_plv;
    string             e_tag = "R1";
    int                since_rst = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_fuse[i]) m_fuse[i] = 0;
            foreach (m_sig[i]) m_sig[i] = 0;
            m_prot = 0; m_stall = 0;
            e_ready = 1; e_rv = 0; e_rj = 0; e_pl = 0; e_data = 0; e_plv = 0;
            e_tag = "R1";
            since_rst = 0;
        end else begin
            since_rst++;
            e_rv = 0; e_rj = 0; e_pl = 0; e_data = 0;
            e_tag = (since_rst < 2) ? "R1" : "R2";
            if (m_stall > 0) begin
                m_stall--;
                if (m_stall == 0) begin
                    foreach (m_fuse[i]) m_fuse[i] = 0;
                    m_prot = 0;
                end
            end else if (cmd_valid) begin
                e_rv = 1;
                case (cmd_op)
                    3'd0: begin m_fuse[cmd_addr] = cmd_wdata; e_tag = m_prot ? "R7" : "R3"; end
                    3'd1: begin
                        if (m_prot) begin e_rj = 1; e_tag = "R5"; end
                        else begin e_data = m_fuse[cmd_addr]; e_tag = "R3"; end
                    end
                    3'd2: begin e_data = m_sig[cmd_addr % 8]; e_tag = "R4"; end
                    3'd3: begin m_sig[cmd_addr % 8] = cmd_wdata & 32'hFF; e_tag = "R4"; end
                    3'd4: begin e_tag = m_prot ? "R10" : "R5"; m_prot = 1; end
                    3'd5: begin
                        e_tag = "R6";
                        if (m_prot) e_rj = 1;
                        else begin e_pl = 1; e_plv = cmd_wdata & 32'hFF; end
                    end
                    3'd6: begin m_stall = ROWS; e_tag = "R8"; end
                    default: begin e_rj = 1; e_tag = "R9"; end
                endcase
            end
            e_ready = (m_stall == 0);
        end
    end

    // ---------------- comparison ----------------
    int vectors = 0;
    int fails   = 0;

    task automatic cmp(input string tag, input string what, input longint got, input longint exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp((e_ready == 0 || e_tag == "R8") ? "R8" : e_tag, "cmd_ready", cmd_ready, e_ready);
            cmp(e_tag == "R1" ? "R1" : "R2", "rsp_valid", rsp_valid, e_rv);
            cmp(e_tag, "rsp_reject", rsp_reject, e_rj);
            cmp(e_tag, "rsp_data", rsp_data, e_data);
            cmp(e_tag == "R1" ? "R1" : "R6", "pl_strobe", pl_strobe, e_pl);
            cmp(e_tag == "R1" ? "R1" : "R6", "pl_value", pl_value, e_plv);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input int op, input int addr, input int unsigned data);
        bit r;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_addr  = ADDR_W'(addr);
        cmd_wdata = data;
        forever begin
            r = cmd_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_run(input int n, input int max_op);
        for (int k = 0; k < n; k++) begin
            send($urandom_range(0, max_op), $urandom_range(0, ROWS - 1), $urandom);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 2));
        end
    endtask

    bit done = 0;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: empty store after reset
        send(2, 0, 0);
        send(1, 3, 0);
        idle(1);
        // R3: write every row, then verify back to back
        for (int r = 0; r < ROWS; r++) send(0, r, 32'hC0DE0000 ^ (r * 32'h01010101));
        for (int r = 0; r < ROWS; r++) send(1, r, 0);
        idle(2);
        // R4: signature bytes
        for (int b = 0; b < 8; b++) send(3, b, 32'hFFFF_FF00 | (8'h31 + b));
        for (int b = 7; b >= 0; b--) send(2, b, 0);
        // R6: register forcing
        send(5, 0, 32'h0000_00A5);
        idle(1);
        send(5, 0, 32'h1234_565A);
        send(5, 0, 32'h0000_0000);
        send(5, 0, 32'h0000_00FF);
        // R9: reserved code
        send(7, 5, 32'hDEAD_BEEF);
        send(1, 5, 0);
        idle(1);
        rand_run(200, 3);
        rand_run(60, 5 - 2);
        send(7, 1, 0);
        // R5: protect, verify on the very next edge
        send(4, 0, 0);
        send(1, 1, 0);
        send(5, 0, 32'h0000_0042);   // R6 refused
        send(2, 2, 0);               // R4 still readable
        send(3, 2, 32'h77);
        send(2, 2, 0);
        send(0, 4, 32'hABCD_0123);   // R7
        send(4, 0, 0);               // R10
        send(1, 4, 0);
        for (int k = 0; k < 100; k++) begin
            int o;
            o = $urandom_range(0, 5);
            send(o, $urandom_range(0, ROWS - 1), $urandom);
        end
        // R8: erase; a verify held during the stall
        send(6, 0, 0);
        send(1, 4, 0);
        send(1, 0, 0);
        send(2, 2, 0);
        send(5, 0, 32'h3C);
        idle(3);
        send(6, 0, 0);
        idle(ROWS + 2);
        rand_run(300, 7);
        idle(ROWS + 4);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule